// File: doc/BRIEF.md
# Vectored Interrupt Controller with Level Encoding

This block gathers interrupt requests from eight active-low external pins and a parameterised set of active-high internal peripheral lines, keeps one status bit per source, and drives a 3-bit priority level to the processor. Each source has a fixed level. The level output is the highest level among the sources that are both pending and unmasked.

Each external pin can be set to capture in one of two ways. In level mode its status bit follows the synchronised pin. In edge mode a falling edge latches the bit, and software clears it by writing a one to it. Internal lines are always level-sensitive.

When the processor acknowledges an interrupt, it raises a one-cycle strobe together with the level it is serving. The block then returns an 8-bit vector built from a programmable 5-bit base and that level. Until the base register has been written at least once, the fixed value 0x0F is returned instead.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the level output is 0, every status bit is 0, every mask bit is 1 (masked), every external capture-mode bit is 0 (level), and the vector register reads 0x00.
- R2: An external pin in level mode (mode bit 0) shows status 1 three clock edges after it goes low, and status 0 three edges after it returns high. Writing 1 to its status bit has no effect.
- R3: An external pin in edge mode (mode bit 1) sets its status bit three edges after a falling edge. The bit stays set after the pin returns high, is cleared by writing 1 to it, and is left unchanged by writing 0.
- R4: When a falling edge is detected on the same edge as a write-one-to-clear of that bit, the status bit stays set.
- R5: Internal line j sets status bit 8+j one edge after it is driven, follows it while it is held, and ignores writes to the status register. The capture-mode register holds only bits 7:0, and its upper bits read 0.
- R6: Status bits are captured whether or not the source is masked (mask bit 1). Masked sources never raise the level output.
- R7: The level output is the highest level among pending, unmasked sources, and 0 when there are none. The levels are fixed per source: pins 0–3 use level 5; pins 4, 5, 6 and 7 use levels 1, 2, 3 and 6; even internal lines use level 4 and odd internal lines use level 7.
- R8: While ack is high and the base has been written, vec_out is {base[4:0], ack_level}. While ack is low, vec_out is 0x00.
- R9: While ack is high and the base register has not been written since reset, vec_out is 0x0F.
- R10: The vector register (address 0) stores write-data bits 7:3 and reads back with bits 2:0 as 0. The register addresses are: 0 vector base, 1 status, 2 mask, 3 capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | 8 | Active-low external requests: pins 0–3 general, pins 4–7 fixed-level lines |
| periph_irq | input | NUM_PERIPH | Active-high internal peripheral requests |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8+NUM_PERIPH | Register write data |
| reg_rdata | output | 8+NUM_PERIPH | Register read data, combinational from reg_addr |
| irq_level | output | 3 | Highest pending unmasked level, 0 for none |
| ack | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| vec_out | output | 8 | Returned vector number |

## Verification
Several properties are checked on every cycle:
- the level output is 0 whenever no unmasked source is pending;
- a nonzero level always has a pending unmasked source behind it;
- internal status bits track the peripheral lines one cycle later;
- the vector output is 0x0F before programming, carries ack_level in its low bits afterwards, and is 0 while ack is low;
- the programmed flag never falls back.

Other behaviour needs the bench's scenarios:
- the three-edge capture latency;
- edge latching and write-one-to-clear;
- the race between a new edge and a clear;
- the correct choice of the highest level under random mixes of requests and masks.

// File: rtl/virq_pkg.sv
package virq_pkg;

    localparam int EXT_N      = 8;
    localparam int GEN_PINS   = 4;
    localparam int LEVEL_W    = 3;
    localparam int VEC_W      = 8;
    localparam int BASE_W     = VEC_W - LEVEL_W;
    localparam logic [VEC_W-1:0] UNINIT_VEC = 8'h0F;

    typedef enum logic [1:0] {
        REG_VBASE  = 2'd0,
        REG_STATUS = 2'd1,
        REG_MASK   = 2'd2,
        REG_MODE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               strobe;
        logic [LEVEL_W-1:0] level;
    } ack_req_t;

    // Fixed priority level of each status bit.
    function automatic logic [LEVEL_W-1:0] src_level(input int idx);
        logic [LEVEL_W-1:0] lv;
        if (idx < GEN_PINS) begin
            lv = 3'd5;
        end else if (idx < EXT_N) begin
            case (idx - GEN_PINS)
                0:       lv = 3'd1;
                1:       lv = 3'd2;
                2:       lv = 3'd3;
                default: lv = 3'd6;
            endcase
        end else begin
            lv = (((idx - EXT_N) % 2) == 0) ? 3'd4 : 3'd7;
        end
        return lv;
    endfunction

endpackage

// File: rtl/virq_capture.sv
module virq_capture
    import virq_pkg::*;
#(
    parameter int NSRC        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [EXT_N-1:0]   ext_n,
    input  logic [NSRC-EXT_N-1:0] periph,
    input  logic [EXT_N-1:0]   edge_mode,
    input  logic [EXT_N-1:0]   clr,
    output logic [NSRC-1:0]    status
);

    localparam int NPER = NSRC - EXT_N;

    for (genvar g = 0; g < EXT_N; g++) begin : g_ext
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev_s;
        logic                   synced;
        logic                   fall;
        logic                   st_q;

        assign synced = chain[SYNC_STAGES-1];
        assign fall   = prev_s & ~synced;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= '1;
                prev_s <= 1'b1;
                st_q   <= 1'b0;
            end else begin
                chain  <= {chain[SYNC_STAGES-2:0], ext_n[g]};
                prev_s <= synced;
                if (edge_mode[g]) begin
                    if (fall)        st_q <= 1'b1;
                    else if (clr[g]) st_q <= 1'b0;
                end else begin
                    st_q <= ~synced;
                end
            end
        end

        assign status[g] = st_q;
    end

    for (genvar g = 0; g < NPER; g++) begin : g_per
        logic st_q;
        always_ff @(posedge clk) begin
            if (rst) st_q <= 1'b0;
            else     st_q <= periph[g];
        end
        assign status[EXT_N+g] = st_q;
    end

endmodule

// File: rtl/virq_level_enc.sv
module virq_level_enc
    import virq_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic [NSRC-1:0]    status,
    input  logic [NSRC-1:0]    mask,
    output logic [LEVEL_W-1:0] level
);

    localparam int NLEV = 1 << LEVEL_W;

    logic [NSRC-1:0] pend;
    logic [NLEV-1:0] any_lv;

    assign pend = status & ~mask;

    always_comb begin
        any_lv = '0;
        for (int i = 0; i < NSRC; i++) begin
            any_lv[src_level(i)] = any_lv[src_level(i)] | pend[i];
        end
    end

    always_comb begin
        level = '0;
        for (int l = 0; l < NLEV; l++) begin
            if (any_lv[l]) level = LEVEL_W'(l);
        end
    end

endmodule

// File: rtl/virq_vector_fmt.sv
module virq_vector_fmt
    import virq_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic              programmed,
    input  ack_req_t          req,
    output logic [VEC_W-1:0]  vec
);

    always_comb begin
        if (!req.strobe)     vec = '0;
        else if (!programmed) vec = UNINIT_VEC;
        else                 vec = {base, req.level};
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import virq_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [EXT_N-1:0]          ext_irq_n,
    input  logic [NUM_PERIPH-1:0]     periph_irq,
    input  logic [1:0]                reg_addr,
    input  logic                      reg_wr,
    input  logic [EXT_N+NUM_PERIPH-1:0] reg_wdata,
    output logic [EXT_N+NUM_PERIPH-1:0] reg_rdata,
    output logic [LEVEL_W-1:0]        irq_level,
    input  logic                      ack,
    input  logic [LEVEL_W-1:0]        ack_level,
    output logic [VEC_W-1:0]          vec_out
);

    localparam int NSRC = EXT_N + NUM_PERIPH;

    reg_sel_e          sel;
    logic [BASE_W-1:0] vbase_q;
    logic              vprog_q;
    logic [NSRC-1:0]   mask_q;
    logic [EXT_N-1:0]  mode_q;
    logic [EXT_N-1:0]  clr;
    logic [NSRC-1:0]   status_q;
    ack_req_t          ack_req;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            vbase_q <= '0;
            vprog_q <= 1'b0;
            mask_q  <= '1;
            mode_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                REG_VBASE: begin
                    vbase_q <= reg_wdata[VEC_W-1:LEVEL_W];
                    vprog_q <= 1'b1;
                end
                REG_MASK:  mask_q <= reg_wdata;
                REG_MODE:  mode_q <= reg_wdata[EXT_N-1:0];
                default:   ;
            endcase
        end
    end

    assign clr = (reg_wr && sel == REG_STATUS) ? reg_wdata[EXT_N-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_VBASE:  reg_rdata[VEC_W-1:0] = {vbase_q, {LEVEL_W{1'b0}}};
            REG_STATUS: reg_rdata = status_q;
            REG_MASK:   reg_rdata = mask_q;
            default:    reg_rdata[EXT_N-1:0] = mode_q;
        endcase
    end

    virq_capture #(
        .NSRC(NSRC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_capture (
        .clk(clk),
        .rst(rst),
        .ext_n(ext_irq_n),
        .periph(periph_irq),
        .edge_mode(mode_q),
        .clr(clr),
        .status(status_q)
    );

    virq_level_enc #(
        .NSRC(NSRC)
    ) u_level (
        .status(status_q),
        .mask(mask_q),
        .level(irq_level)
    );

    assign ack_req.strobe = ack;
    assign ack_req.level  = ack_level;

    virq_vector_fmt u_vec (
        .base(vbase_q),
        .programmed(vprog_q),
        .req(ack_req),
        .vec(vec_out)
    );

endmodule

// File: rtl/virq_checker.sv
module virq_checker
    import virq_pkg::*;
#(
    parameter int NSRC = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NSRC-1:0]       status_q,
    input logic [NSRC-1:0]       mask_q,
    input logic                  vprog_q,
    input logic [NSRC-EXT_N-1:0] periph_irq,
    input logic [LEVEL_W-1:0]    irq_level,
    input logic                  ack,
    input logic [LEVEL_W-1:0]    ack_level,
    input logic [VEC_W-1:0]      vec_out
);

    AST_RESET_CLEARS_STATUS: assert property (@(posedge clk)
        rst |=> (status_q == '0 && irq_level == '0)); // R1

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q) == '0) |-> (irq_level == '0)); // R6

    AST_LEVEL_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> ((status_q & ~mask_q) != '0)); // R7

    AST_PERIPH_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (status_q[NSRC-1:EXT_N] == $past(periph_irq))); // R5

    AST_UNINIT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (ack && !vprog_q) |-> (vec_out == UNINIT_VEC)); // R9

    AST_PROG_STICKY: assert property (@(posedge clk) disable iff (rst)
        vprog_q |=> vprog_q); // R9

    AST_VECTOR_LEVEL_BITS: assert property (@(posedge clk) disable iff (rst)
        (ack && vprog_q) |-> (vec_out[LEVEL_W-1:0] == ack_level)); // R8

    AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (vec_out == '0)); // R8

endmodule

bind vec_irq_ctrl virq_checker #(
    .NSRC(NSRC)
) u_checker (
    .clk(clk),
    .rst(rst),
    .status_q(status_q),
    .mask_q(mask_q),
    .vprog_q(vprog_q),
    .periph_irq(periph_irq),
    .irq_level(irq_level),
    .ack(ack),
    .ack_level(ack_level),
    .vec_out(vec_out)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPER = 8;
    localparam int NSRC = 8 + NPER;
    localparam int WATCHDOG_CYCLES = 100000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      ext_irq_n = 8'hFF;
    logic [NPER-1:0] periph_irq = '0;
    logic [1:0]      reg_addr = 2'd0;
    logic            reg_wr = 1'b0;
    logic [NSRC-1:0] reg_wdata = '0;
    logic [NSRC-1:0] reg_rdata;
    logic [2:0]      irq_level;
    logic            ack = 1'b0;
    logic [2:0]      ack_level = 3'd0;
    logic [7:0]      vec_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl #(.NUM_PERIPH(NPER)) u_vec_irq_ctrl (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .periph_irq(periph_irq),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_level(irq_level), .ack(ack),
        .ack_level(ack_level), .vec_out(vec_out)
    );

    function automatic logic [2:0] lvl_of(input int idx);
        if (idx < 4) return 3'd5;
        if (idx == 4) return 3'd1;
        if (idx == 5) return 3'd2;
        if (idx == 6) return 3'd3;
        if (idx == 7) return 3'd6;
        return ((idx - 8) % 2 == 0) ? 3'd4 : 3'd7;
    endfunction

    function automatic logic [2:0] exp_level(input logic [NSRC-1:0] st, input logic [NSRC-1:0] mk);
        logic [2:0] best = 3'd0;
        for (int i = 0; i < NSRC; i++)
            if (st[i] && !mk[i] && lvl_of(i) > best) best = lvl_of(i);
        return best;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [NSRC-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [NSRC-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] d;
        void'($urandom(32'h5EED1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 level", irq_level, 0);
        rd(2'd1, d); chk("R1 status", d, 0);
        rd(2'd2, d); chk("R1 mask", d, 16'hFFFF);
        rd(2'd3, d); chk("R1 mode", d, 0);
        rd(2'd0, d); chk("R1 vbase", d, 0);

        // R9 uninitialized vector
        ack = 1'b1; ack_level = 3'd3; #1;
        chk("R9 uninit vector", vec_out, 8'h0F);
        ack = 1'b0; #1;
        chk("R8 idle vector", vec_out, 0);

        // R10 vector register, R8 formed vector
        wr(2'd0, 16'h00AD);
        rd(2'd0, d); chk("R10 vbase readback", d, 16'h00A8);
        ack = 1'b1; ack_level = 3'd5; #1;
        chk("R8 formed vector", vec_out, 8'hAD);
        ack = 1'b0;

        // R6 masked source latches but stays quiet
        periph_irq = 8'h02; tick();
        rd(2'd1, d); chk("R6 masked status latched", d[9], 1);
        chk("R6 masked level", irq_level, 0);
        periph_irq = 8'h00;
        wr(2'd2, 16'h0000);
        tick();

        // R2 level mode on pin 4 (level 1)
        ext_irq_n[4] = 1'b0;
        tick(); tick();
        rd(2'd1, d); chk("R2 not yet", d[4], 0);
        tick();
        rd(2'd1, d); chk("R2 status low pin", d[4], 1);
        chk("R2 level", irq_level, 1);
        wr(2'd1, 16'h0010);
        rd(2'd1, d); chk("R2 w1c ignored", d[4], 1);
        ext_irq_n[4] = 1'b1;
        tick(); tick(); tick();
        rd(2'd1, d); chk("R2 released", d[4], 0);
        chk("R2 level cleared", irq_level, 0);

        // R3 edge mode on pin 7 (level 6)
        wr(2'd3, 16'h0080);
        ext_irq_n[7] = 1'b0;
        tick(); tick(); tick();
        rd(2'd1, d); chk("R3 edge set", d[7], 1);
        ext_irq_n[7] = 1'b1;
        tick(); tick(); tick();
        rd(2'd1, d); chk("R3 held after release", d[7], 1);
        chk("R3 level", irq_level, 6);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); chk("R3 write0 keeps", d[7], 1);
        wr(2'd1, 16'h0080);
        rd(2'd1, d); chk("R3 w1c clears", d[7], 0);
        chk("R3 level cleared", irq_level, 0);

        // R4 new edge beats simultaneous clear
        ext_irq_n[7] = 1'b0;
        tick(); tick(); tick();
        ext_irq_n[7] = 1'b1;
        tick(); tick(); tick(); tick();
        ext_irq_n[7] = 1'b0;
        tick(); tick();
        wr(2'd1, 16'h0080);
        rd(2'd1, d); chk("R4 edge wins", d[7], 1);
        wr(2'd1, 16'h0080);
        rd(2'd1, d); chk("R4 later clear", d[7], 0);
        ext_irq_n[7] = 1'b1;
        tick(); tick(); tick();

        // R5 internal lines ignore mode and clears
        wr(2'd3, 16'hFF80);
        rd(2'd3, d); chk("R5 mode upper bits", d, 16'h0080);
        periph_irq = 8'h01; tick();
        rd(2'd1, d); chk("R5 internal set", d[8], 1);
        chk("R5 level 4", irq_level, 4);
        wr(2'd1, 16'h0100);
        rd(2'd1, d); chk("R5 w1c ignored", d[8], 1);
        periph_irq = 8'h03; tick();
        chk("R7 odd line level 7", irq_level, 7);
        wr(2'd2, 16'h0200);
        chk("R6 mask lowers level", irq_level, 4);
        periph_irq = 8'h00; tick();
        rd(2'd1, d); chk("R5 internal clear", d[15:8], 0);
        wr(2'd3, 16'h0000);
        tick(); tick(); tick();

        // R7 / R8 random mix of internal requests, masks and acks
        for (int k = 0; k < 400; k++) begin
            logic [NPER-1:0] pr;
            logic [NSRC-1:0] mk;
            logic [2:0]      al;
            pr = NPER'($urandom);
            mk = NSRC'($urandom);
            al = 3'($urandom);
            periph_irq = pr;
            wr(2'd2, mk);
            rd(2'd1, d); chk("R5 random status", d, {pr, 8'h00});
            chk("R7 random level", irq_level, exp_level({pr, 8'h00}, mk));
            ack = 1'b1; ack_level = al; #1;
            chk("R8 random vector", vec_out, {5'b10101, al});
            ack = 1'b0;
        end

        // R7 external pins mixed with internal lines
        periph_irq = 8'h00;
        wr(2'd2, 16'h0000);
        ext_irq_n = 8'b1101_1110;
        tick(); tick(); tick();
        chk("R7 pin0 over pin5", irq_level, 5);
        wr(2'd2, 16'h000F);
        chk("R7 masked pin0", irq_level, 2);
        ext_irq_n = 8'hFF;
        tick(); tick(); tick();
        chk("R7 none pending", irq_level, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule